// File: doc/BRIEF.md
# LIN Transceiver Power Mode Sequencer

This block is the digital mode controller of a single-wire automotive bus transceiver. It steps the transceiver through five power modes: power-on hold, Ready, Operation, Transmitter-Off and Power-Down. For each mode it drives the enables for the external voltage regulator, the bus receiver, the bus driver and the bus pull-up resistor. Other logic measures the supply level, times the bus wake-up and runs the fault timers. This block receives their results as single-bit flags.

The host microcontroller controls the mode with a chip-select line, together with the TXD level and a transmit-enable line. Chip select first passes through a counting glitch filter, so a short pulse can neither wake the transceiver nor send it to sleep. A falling edge of the filtered chip select puts the device to sleep. When chip select goes high, the TXD and enable levels at that moment decide whether the device starts in Operation or in Transmitter-Off.

Top module: `lin_pwr_seq`

## Requirements
- R1: While reset is asserted, the mode code is 0 (power-on hold) and the regulator, receiver, transmitter and pull-up enables are all 0.
- R2: In mode 0, the mode stays 0 while `supply_ok` is low. On the first clock with `supply_ok` high, the next mode is chosen from the filtered chip select: low gives Ready (code 1); high gives Operation (code 2) when `txd`=1, `tx_enable`=1 and `fault`=0, and Transmitter-Off (code 3) otherwise.
- R3: In Ready, the regulator and receiver enables are 1 and the transmitter and pull-up enables are 0. On a clock where the filtered chip select is high, the mode moves to 2 or 3 under the same condition as in R2.
- R4: In Operation, all four enables are 1. The pull-up enable is 1 in no other mode.
- R5: In Operation without a filtered chip-select falling edge, `fault`=1 or `tx_enable`=0 moves the mode to 3 on the next clock. A low `txd` alone keeps the mode at 2.
- R6: In Transmitter-Off, the regulator and receiver enables are 1 and the transmitter and pull-up enables are 0. The mode returns to 2 only on a clock with `fault`=0, `txd`=1 and `tx_enable`=1.
- R7: A falling edge of the filtered chip select in mode 2 or mode 3 moves the mode to Power-Down (code 4) on the next clock. This takes priority over a fault and over a return to Operation. In mode 4, all four enables are 0.
- R8: In mode 4, a clock with the filtered chip select high or with `wake_evt`=1 moves the mode to 1. From there R3 applies.
- R9: The filtered chip select takes a new level only after the raw input has held that level for `FILT_CNT` consecutive clocks. It changes on the `FILT_CNT`-th edge that samples the new level, and the mode reacts one clock later. A shorter pulse changes neither the filtered level nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply is above the start threshold |
| cs_raw | input | 1 | Unfiltered chip select from the host |
| txd | input | 1 | Transmit data level from the host |
| tx_enable | input | 1 | Transmit enable line (tie high when unused) |
| fault | input | 1 | A supervisor fault is present |
| wake_evt | input | 1 | Wake event from the bus or local wake detector |
| reg_en | output | 1 | External regulator enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Bus driver enable |
| pullup_en | output | 1 | Bus pull-up connect |
| mode_code | output | 3 | Current mode code (0..4) |

## Verification
Two conditions can arrive in the same clock while the device is in Operation: a supervisor fault and the filtered chip-select falling edge. The bench raises `fault` on the clock where the filter output drops, and expects the mode to go to Power-Down rather than Transmitter-Off. It also makes a wake event coincide with a rising filtered chip select in Power-Down, and expects a single step to Ready followed by the R3 decision. A behavioural model is compared with the mode and the enables on every clock, and directed checks confirm the expected mode at the key points.

// File: rtl/lin_pwr_pkg.sv
package lin_pwr_pkg;

  typedef enum logic [2:0] {
    ST_POR   = 3'd0,
    ST_READY = 3'd1,
    ST_OPER  = 3'd2,
    ST_TXOFF = 3'd3,
    ST_PDOWN = 3'd4
  } pwr_state_t;

  typedef struct packed {
    logic reg_en;
    logic rx_en;
    logic tx_en;
    logic pullup_en;
  } pwr_out_t;

  // Transmission may run: data idle high, enable high, no fault.
  function automatic logic tx_may_run(input logic txd, input logic ten,
                                      input logic flt);
    return txd & ten & ~flt;
  endfunction

  // Mode chosen once the filtered chip select is seen high.
  function automatic pwr_state_t active_target(input logic txd, input logic ten,
                                               input logic flt);
    return tx_may_run(txd, ten, flt) ? ST_OPER : ST_TXOFF;
  endfunction

  function automatic pwr_out_t mode_outputs(input pwr_state_t st);
    pwr_out_t o;
    o = '0;
    case (st)
      ST_READY, ST_TXOFF: begin o.reg_en = 1'b1; o.rx_en = 1'b1; end
      ST_OPER:            o = 4'b1111;
      default:            o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/cs_glitch_filter.sv
module cs_glitch_filter #(
  parameter int FILT_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CNT - 1);

  logic [CW-1:0] run_cnt;
  logic          differs;

  assign differs = raw ^ filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt    <= 1'b0;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      filt    <= raw;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R9: the output only ever takes the level the raw input had
  p_filt_follows_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> filt == $past(raw));

  // R9: an input matching the output leaves it unchanged
  p_filt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (raw == filt) |=> $stable(filt));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import lin_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_f,
  input  logic       txd,
  input  logic       tx_enable,
  input  logic       fault,
  input  logic       wake_evt,
  output pwr_state_t state
);
  pwr_state_t nxt;
  logic       cs_q;
  logic       cs_fall;
  logic       drop_tx;
  logic       may_run;

  assign cs_fall = cs_q & ~cs_f;
  assign drop_tx = fault | ~tx_enable;
  assign may_run = tx_may_run(txd, tx_enable, fault);

  always_comb begin
    nxt = state;
    case (state)
      ST_POR:   if (supply_ok) nxt = cs_f ? active_target(txd, tx_enable, fault) : ST_READY;
      ST_READY: if (cs_f) nxt = active_target(txd, tx_enable, fault);
      ST_OPER:  if (cs_fall) nxt = ST_PDOWN;
                else if (drop_tx) nxt = ST_TXOFF;
      ST_TXOFF: if (cs_fall) nxt = ST_PDOWN;
                else if (may_run) nxt = ST_OPER;
      ST_PDOWN: if (cs_f || wake_evt) nxt = ST_READY;
      default:  nxt = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_POR;
      cs_q  <= 1'b0;
    end else begin
      state <= nxt;
      cs_q  <= cs_f;
    end
  end

  p_por_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POR && !supply_ok) |=> state == ST_POR);

  p_fault_leaves_oper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPER && !cs_fall && (fault || !tx_enable)) |=> state == ST_TXOFF);

  p_txoff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TXOFF && !cs_fall && (fault || !txd || !tx_enable)) |=> state == ST_TXOFF);

  p_csfall_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_OPER || state == ST_TXOFF) && cs_fall) |=> state == ST_PDOWN);

  p_wake_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDOWN && (cs_f || wake_evt)) |=> state == ST_READY);

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import lin_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_t state,
  output logic       reg_en,
  output logic       rx_en,
  output logic       tx_en,
  output logic       pullup_en
);
  pwr_out_t o;

  assign o         = mode_outputs(state);
  assign reg_en    = o.reg_en;
  assign rx_en     = o.rx_en;
  assign tx_en     = o.tx_en;
  assign pullup_en = o.pullup_en;

  // R4: the driver and the pull-up are never on without the regulator
  p_drive_needs_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en || pullup_en) |-> (reg_en && rx_en));

  // R7: asleep means everything off
  p_sleep_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDOWN) |-> !(reg_en || rx_en || tx_en || pullup_en));

endmodule

// File: rtl/lin_pwr_seq.sv
module lin_pwr_seq
  import lin_pwr_pkg::*;
#(
  parameter int FILT_CNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_raw,
  input  logic       txd,
  input  logic       tx_enable,
  input  logic       fault,
  input  logic       wake_evt,
  output logic       reg_en,
  output logic       rx_en,
  output logic       tx_en,
  output logic       pullup_en,
  output logic [2:0] mode_code
);
  logic       cs_f;
  pwr_state_t state;

  cs_glitch_filter #(.FILT_CNT(FILT_CNT)) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (cs_raw),
    .filt (cs_f)
  );

  pwr_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .cs_f     (cs_f),
    .txd      (txd),
    .tx_enable(tx_enable),
    .fault    (fault),
    .wake_evt (wake_evt),
    .state    (state)
  );

  pwr_out_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .reg_en   (reg_en),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .pullup_en(pullup_en)
  );

  assign mode_code = state;

endmodule

// File: tb/lin_pwr_seq_test.sv
module lin_pwr_seq_test;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, cs_raw = 1'b0, txd = 1'b1, tx_enable = 1'b1;
  logic fault = 1'b0, wake_evt = 1'b0;
  logic reg_en, rx_en, tx_en, pullup_en;
  logic [2:0] mode_code;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lin_pwr_seq #(.FILT_CNT(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_raw(cs_raw),
    .txd(txd), .tx_enable(tx_enable), .fault(fault), .wake_evt(wake_evt),
    .reg_en(reg_en), .rx_en(rx_en), .tx_en(tx_en), .pullup_en(pullup_en),
    .mode_code(mode_code)
  );

  // Behavioural reference: mode number, filtered level, previous level, run length
  int m_mode = 0, m_lvl = 0, m_prev = 0, m_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_lvl = 0; m_prev = 0; m_run = 0;
    end else begin
      int nx;
      bit go, fell;
      go   = txd && tx_enable && !fault;
      fell = (m_prev == 1) && (m_lvl == 0);
      nx = m_mode;
      if (m_mode == 0 && supply_ok) nx = (m_lvl == 1) ? (go ? 2 : 3) : 1;
      else if (m_mode == 1 && m_lvl == 1) nx = go ? 2 : 3;
      else if (m_mode == 2) nx = fell ? 4 : ((fault || !tx_enable) ? 3 : 2);
      else if (m_mode == 3) nx = fell ? 4 : (go ? 2 : 3);
      else if (m_mode == 4 && (m_lvl == 1 || wake_evt)) nx = 1;
      m_mode = nx;
      m_prev = m_lvl;
      if (int'(cs_raw) == m_lvl) m_run = 0;
      else begin
        m_run++;
        if (m_run == FILT) begin m_lvl = int'(cs_raw); m_run = 0; end
      end
    end
  end

  function automatic string mode_tag(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R5";
      3: return "R6";
      default: return "R8";
    endcase
  endfunction

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er, ex, et, ep;
      er = (m_mode == 1 || m_mode == 2 || m_mode == 3) ? 1 : 0;
      et = (m_mode == 2) ? 1 : 0;
      ep = et;
      ex = er;
      total++;
      if (int'(mode_code) != m_mode) begin
        bad++;
        $display("FAIL %s mode: actual=%0d expected=%0d at %0t", mode_tag(m_mode), mode_code, m_mode, $time);
      end
      total++;
      if (int'(reg_en) != er || int'(rx_en) != ex || int'(tx_en) != et || int'(pullup_en) != ep) begin
        bad++;
        $display("FAIL R4 enables: actual=%b%b%b%b expected=%0d%0d%0d%0d at %0t",
                 reg_en, rx_en, tx_en, pullup_en, er, ex, et, ep, $time);
      end
    end
  end

  task automatic expect_mode(input int exp, input string tag);
    total++;
    if (int'(mode_code) != exp) begin
      bad++;
      $display("FAIL %s directed: actual=%0d expected=%0d", tag, mode_code, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    cyc(3);
    total++;
    if (mode_code != 3'd0 || reg_en || rx_en || tx_en || pullup_en) begin
      bad++;
      $display("FAIL R1 reset: actual=%0d/%b%b%b%b expected=0/0000", mode_code, reg_en, rx_en, tx_en, pullup_en);
    end
    rst_n = 1'b1;
    cyc(5);
    expect_mode(0, "R2 wait for supply");
    supply_ok = 1'b1;
    cyc(2);
    expect_mode(1, "R2 to ready");

    // R9: glitch shorter than the filter
    cs_raw = 1'b1; cyc(FILT - 1); cs_raw = 1'b0;
    cyc(6);
    expect_mode(1, "R9 glitch ignored");

    // R3: chip select high with txd low -> transmitter off
    txd = 1'b0; cs_raw = 1'b1;
    cyc(FILT);
    expect_mode(1, "R9 latency");
    cyc(1);
    expect_mode(3, "R3 to txoff");
    cyc(2);
    expect_mode(3, "R6 holds with txd low");
    txd = 1'b1; cyc(1);
    expect_mode(2, "R6 return");
    txd = 1'b0; cyc(3);
    expect_mode(2, "R5 txd low stays");
    txd = 1'b1;
    fault = 1'b1; cyc(1);
    expect_mode(3, "R5 fault");
    cyc(2);
    expect_mode(3, "R6 fault holds");
    fault = 1'b0; cyc(1);
    expect_mode(2, "R6 fault cleared");
    tx_enable = 1'b0; cyc(1);
    expect_mode(3, "R5 enable low");
    tx_enable = 1'b1; cyc(1);
    expect_mode(2, "R6 enable back");

    // R9: short low pulse does not sleep
    cs_raw = 1'b0; cyc(FILT - 1); cs_raw = 1'b1;
    cyc(6);
    expect_mode(2, "R9 low glitch ignored");

    // R7: fault and chip-select fall in the same cycle
    cs_raw = 1'b0;
    cyc(FILT);
    fault = 1'b1;
    cyc(1);
    expect_mode(4, "R7 sleep wins over fault");
    fault = 1'b0;
    cyc(3);
    expect_mode(4, "R7 stays asleep");

    // R8: wake event
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0;
    expect_mode(1, "R8 wake to ready");
    cyc(3);
    expect_mode(1, "R3 ready holds with cs low");

    // sleep again from operation, then wake by chip select plus wake at once
    cs_raw = 1'b1; cyc(FILT + 1);
    expect_mode(2, "R3 to operation");
    cs_raw = 1'b0; cyc(FILT + 1);
    expect_mode(4, "R7 sleep from operation");
    cs_raw = 1'b1; cyc(FILT);
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0;
    expect_mode(1, "R8 cs and wake together");
    cyc(1);
    expect_mode(2, "R3 continue to operation");

    // sleep from transmitter off
    fault = 1'b1; cyc(1);
    expect_mode(3, "R5 fault again");
    cs_raw = 1'b0; cyc(FILT + 1);
    expect_mode(4, "R7 sleep from txoff");
    fault = 1'b0;

    // R2: start with chip select already high
    rst_n = 1'b0; supply_ok = 1'b0; cs_raw = 1'b1; txd = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(FILT + 2);
    expect_mode(0, "R2 no supply");
    supply_ok = 1'b1; cyc(1);
    expect_mode(2, "R2 direct to operation");
    rst_n = 1'b0; supply_ok = 1'b0; txd = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(FILT + 2);
    supply_ok = 1'b1; cyc(1);
    expect_mode(3, "R2 direct to txoff");
    cyc(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule